// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between one requester and its data cache. It watches that requester's memory requests and holds a single lock reservation for load-linked / store-conditional pairs. When the cache reports that a load-linked read has completed, the monitor records the cache line and the requester ID that asked for it. When a store-conditional is presented, the monitor checks that record in the same cycle the request is accepted. If the line and the ID both match, the reservation is consumed and the write goes downstream as an atomic access. If they do not match, the write is dropped and a failure status is returned. An external invalidate port clears the reservation when another agent takes the line away.

Requests enter on a valid/ready stream and leave on a valid/ready stream through one registered stage. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while the output stage holds a request that downstream has not taken (`iss_valid` high, `iss_ready` low). Once `iss_valid` is raised, it stays high with stable payload until `iss_ready` is seen high. The completion, invalidate and status pins are plain single-cycle strobes and cannot apply back-pressure.

Top module: `llsc_monitor`

## Requirements
- R1: After reset `iss_valid` and `sts_valid` are low, `req_ready` is high and no reservation is held, so a store-conditional fails.
- R2: Request kinds are encoded 0 load, 1 store, 2 instruction fetch, 3 load-linked, 4 store-conditional. Downstream kinds are encoded 0 read, 1 write, 2 atomic, 3 fetch. Loads map to read, stores to write, fetches to fetch, and both locked kinds map to atomic.
- R3: A completion strobe of kind 3 (load-linked) sets the reservation to the line `cpl_addr[ADDR_W-1:OFS_W]` and the owner `cpl_id`. Completions of any other kind, including fetch, leave the reservation unchanged.
- R4: A store-conditional whose line and ID match a valid reservation is issued as atomic, reports success (`sts_fail` low) and clears the reservation.
- R5: A store-conditional that does not match, because there is no reservation, the line differs or the ID differs, is not issued and reports failure (`sts_fail` high). The reservation is left unchanged.
- R6: A new load-linked completion overwrites any earlier reservation, including its line and its owner.
- R7: An invalidate whose line matches the reservation clears it, whatever the offset bits. An invalidate for another line has no effect. If a load-linked completion arrives in the same cycle as an invalidate, the completion wins.
- R8: While `iss_valid` is high and `iss_ready` is low, the output payload holds and `req_ready` is low, so no request is accepted.
- R9: Every accepted request produces exactly one `sts_valid` pulse in the cycle after its acceptance, and no pulse appears otherwise.
- R10: The check and the clear take effect at the same edge, so a store-conditional accepted in the cycle right after a successful one, on the same reservation, fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 3 | Request kind (R2 encoding) |
| req_addr | input | ADDR_W | Request byte address |
| req_id | input | ID_W | Requester ID |
| iss_valid | output | 1 | Downstream request valid |
| iss_ready | input | 1 | Downstream takes the request |
| iss_kind | output | 2 | Downstream kind (R2 encoding) |
| iss_addr | output | ADDR_W | Downstream byte address |
| iss_id | output | ID_W | Downstream requester ID |
| sts_valid | output | 1 | Status strobe for an accepted request |
| sts_fail | output | 1 | Store-conditional failed |
| cpl_valid | input | 1 | Completion strobe from the cache |
| cpl_kind | input | 3 | Kind of the completed request |
| cpl_addr | input | ADDR_W | Completed byte address |
| cpl_id | input | ID_W | Completed requester ID |
| inv_valid | input | 1 | Invalidate strobe |
| inv_addr | input | ADDR_W | Invalidated byte address |

## Verification
The embedded properties check on every cycle that a set, a consume or a matching invalidate leaves the reservation in the state it should have on the next edge, that a non-matching store-conditional reports failure, that a failure never comes with an issued request, and that a stalled output holds steady. The mapping of kinds to downstream codes and the decision table over owner IDs, line match and offset can only be shown by the bench's sweeps. So can the fact that a failed check leaves the reservation in place, and the back-to-back store-conditional that has to see the consumed state.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    REQ_LOAD  = 3'd0,
    REQ_STORE = 3'd1,
    REQ_FETCH = 3'd2,
    REQ_LL    = 3'd3,
    REQ_SC    = 3'd4
  } req_kind_t;

  typedef enum logic [1:0] {
    OUT_READ   = 2'd0,
    OUT_WRITE  = 2'd1,
    OUT_ATOMIC = 2'd2,
    OUT_FETCH  = 2'd3
  } out_kind_t;
endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int TAG_W = 12,
  parameter int ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic [ID_W-1:0]  set_id,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             consume_en,
  output logic             rv_valid,
  output logic [TAG_W-1:0] rv_tag,
  output logic [ID_W-1:0]  rv_id
);
  logic             nxt_valid;
  logic [TAG_W-1:0] nxt_tag;
  logic [ID_W-1:0]  nxt_id;

  always_comb begin
    nxt_valid = rv_valid;
    nxt_tag   = rv_tag;
    nxt_id    = rv_id;
    if (consume_en) nxt_valid = 1'b0;
    if (inv_en && (inv_tag == rv_tag)) nxt_valid = 1'b0;
    if (set_en) begin
      nxt_valid = 1'b1;
      nxt_tag   = set_tag;
      nxt_id    = set_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_valid <= 1'b0;
      rv_tag   <= '0;
      rv_id    <= '0;
    end else begin
      rv_valid <= nxt_valid;
      rv_tag   <= nxt_tag;
      rv_id    <= nxt_id;
    end
  end

  AST_LL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> rv_valid && rv_tag == $past(set_tag) && rv_id == $past(set_id)); // R3
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    consume_en && !set_en |=> !rv_valid); // R4
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && rv_valid && inv_tag == rv_tag && !set_en |=> !rv_valid); // R7
endmodule

// File: rtl/llsc_check.sv
module llsc_check
  import llsc_pkg::*;
#(
  parameter int TAG_W = 12,
  parameter int ID_W  = 2
) (
  input  logic [2:0]       kind,
  input  logic [TAG_W-1:0] tag,
  input  logic [ID_W-1:0]  id,
  input  logic             rv_valid,
  input  logic [TAG_W-1:0] rv_tag,
  input  logic [ID_W-1:0]  rv_id,
  output logic [1:0]       out_kind,
  output logic             is_sc,
  output logic             sc_hit
);
  req_kind_t k;
  out_kind_t ok;

  always_comb begin
    k = req_kind_t'(kind);
    unique case (k)
      REQ_STORE:      ok = OUT_WRITE;
      REQ_FETCH:      ok = OUT_FETCH;
      REQ_LL, REQ_SC: ok = OUT_ATOMIC;
      default:        ok = OUT_READ;
    endcase
    out_kind = ok;
    is_sc    = (k == REQ_SC);
    sc_hit   = rv_valid && (rv_tag == tag) && (rv_id == id);
  end
endmodule

// File: rtl/llsc_out_stage.sv
module llsc_out_stage #(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              drop,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ID_W-1:0]   in_id,
  input  logic              iss_ready,
  output logic              iss_valid,
  output logic [1:0]        iss_kind,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [ID_W-1:0]   iss_id,
  output logic              sts_valid,
  output logic              sts_fail
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_kind  <= '0;
      iss_addr  <= '0;
      iss_id    <= '0;
      sts_valid <= 1'b0;
      sts_fail  <= 1'b0;
    end else begin
      sts_valid <= accept;
      sts_fail  <= accept && drop;
      if (accept) begin
        iss_valid <= !drop;
        iss_kind  <= in_kind;
        iss_addr  <= in_addr;
        iss_id    <= in_id;
      end else if (iss_ready) begin
        iss_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_addr) && $stable(iss_kind) && $stable(iss_id)); // R8
  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && sts_fail |-> !iss_valid); // R5
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sts_valid); // R9
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 4,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [1:0]        iss_kind,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [ID_W-1:0]   iss_id,
  output logic              sts_valid,
  output logic              sts_fail,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_kind,
  input  logic [ADDR_W-1:0] cpl_addr,
  input  logic [ID_W-1:0]   cpl_id,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic             accept;
  logic             ll_done;
  logic             rv_valid;
  logic [TAG_W-1:0] rv_tag;
  logic [ID_W-1:0]  rv_id;
  logic [1:0]       map_kind;
  logic             is_sc;
  logic             sc_hit;
  logic             sc_drop;
  logic             sc_take;

  assign req_ready = !iss_valid || iss_ready;
  assign accept    = req_valid && req_ready;
  assign ll_done   = cpl_valid && (cpl_kind == REQ_LL);
  assign sc_drop   = is_sc && !sc_hit;
  assign sc_take   = accept && is_sc && sc_hit;

  llsc_check #(.TAG_W(TAG_W), .ID_W(ID_W)) u_check (
    .kind     (req_kind),
    .tag      (req_addr[ADDR_W-1:OFS_W]),
    .id       (req_id),
    .rv_valid (rv_valid),
    .rv_tag   (rv_tag),
    .rv_id    (rv_id),
    .out_kind (map_kind),
    .is_sc    (is_sc),
    .sc_hit   (sc_hit)
  );

  llsc_resv #(.TAG_W(TAG_W), .ID_W(ID_W)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (ll_done),
    .set_tag    (cpl_addr[ADDR_W-1:OFS_W]),
    .set_id     (cpl_id),
    .inv_en     (inv_valid),
    .inv_tag    (inv_addr[ADDR_W-1:OFS_W]),
    .consume_en (sc_take),
    .rv_valid   (rv_valid),
    .rv_tag     (rv_tag),
    .rv_id      (rv_id)
  );

  llsc_out_stage #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .drop      (sc_drop),
    .in_kind   (map_kind),
    .in_addr   (req_addr),
    .in_id     (req_id),
    .iss_ready (iss_ready),
    .iss_valid (iss_valid),
    .iss_kind  (iss_kind),
    .iss_addr  (iss_addr),
    .iss_id    (iss_id),
    .sts_valid (sts_valid),
    .sts_fail  (sts_fail)
  );

  AST_SC_MISS_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_kind == REQ_SC &&
    !(rv_valid && rv_tag == req_addr[ADDR_W-1:OFS_W] && rv_id == req_id)
    |=> sts_valid && sts_fail); // R5
  AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |-> !req_ready); // R8
endmodule

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_id = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b1;
  logic [1:0]  iss_kind;
  logic [15:0] iss_addr;
  logic [1:0]  iss_id;
  logic        sts_valid, sts_fail;
  logic        cpl_valid = 1'b0;
  logic [2:0]  cpl_kind = '0;
  logic [15:0] cpl_addr = '0;
  logic [1:0]  cpl_id = '0;
  logic        inv_valid = 1'b0;
  logic [15:0] inv_addr = '0;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [15:0] LINE_A = 16'h0120;
  localparam logic [15:0] LINE_A_OFS = 16'h012C;
  localparam logic [15:0] LINE_B = 16'h0130;

  always #2.5 clk = ~clk;

  llsc_monitor i_llsc_monitor (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_id(req_id),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_kind(iss_kind),
    .iss_addr(iss_addr), .iss_id(iss_id),
    .sts_valid(sts_valid), .sts_fail(sts_fail),
    .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_addr(cpl_addr), .cpl_id(cpl_id),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic complete(input logic [2:0] k, input logic [15:0] a, input logic [1:0] id);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_kind = k; cpl_addr = a; cpl_id = id;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic invalidate(input logic [15:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic send(input logic [2:0] k, input logic [15:0] a, input logic [1:0] id,
                      input bit exp_iss, input logic [1:0] exp_k, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " sts_valid"}, 32'(sts_valid), 32'd1);
    check({tag, " sts_fail"}, 32'(sts_fail), 32'(!exp_iss));
    check({tag, " iss_valid"}, 32'(iss_valid), 32'(exp_iss));
    if (exp_iss) begin
      check({tag, " iss_kind"}, 32'(iss_kind), 32'(exp_k));
      check({tag, " iss_addr"}, 32'(iss_addr), 32'(a));
      check({tag, " iss_id"}, 32'(iss_id), 32'(id));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 iss_valid", 32'(iss_valid), 32'd0);
    check("R1 sts_valid", 32'(sts_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    send(3'd4, LINE_A, 2'd0, 1'b0, 2'd0, "R1 sc after reset");

    // R2 kind mapping
    send(3'd0, 16'h0044, 2'd1, 1'b1, 2'd0, "R2 load");
    send(3'd1, 16'h0048, 2'd2, 1'b1, 2'd1, "R2 store");
    send(3'd2, 16'h004C, 2'd3, 1'b1, 2'd3, "R2 fetch");
    send(3'd3, 16'h0050, 2'd0, 1'b1, 2'd2, "R2 load-linked");

    // R3 completions of other kinds set nothing
    for (int k = 0; k < 3; k++) begin
      complete(3'(k), LINE_A, 2'd1);
      send(3'd4, LINE_A, 2'd1, 1'b0, 2'd0, "R3 non-LL completion");
    end

    // R4/R5 sweep over owner, requester and address
    for (int so = 0; so < 4; so++)
      for (int ro = 0; ro < 4; ro++)
        for (int ai = 0; ai < 3; ai++) begin
          logic [15:0] a;
          bit pass;
          a = (ai == 0) ? LINE_A : (ai == 1) ? LINE_A_OFS : LINE_B;
          pass = (so == ro) && (ai != 2);
          complete(3'd3, LINE_A, 2'(so));
          send(3'd4, a, 2'(ro), pass, 2'd2, pass ? "R4 sc match" : "R5 sc mismatch");
          if (pass)
            send(3'd4, LINE_A, 2'(so), 1'b0, 2'd0, "R4 reservation consumed");
          else
            send(3'd4, LINE_A, 2'(so), 1'b1, 2'd2, "R5 reservation kept");
        end

    // R6 overwrite
    complete(3'd3, LINE_A, 2'd0);
    complete(3'd3, LINE_B, 2'd1);
    send(3'd4, LINE_A, 2'd0, 1'b0, 2'd0, "R6 old reservation gone");
    send(3'd4, LINE_B, 2'd1, 1'b1, 2'd2, "R6 new reservation");

    // R7 invalidate
    complete(3'd3, LINE_A, 2'd2);
    invalidate(LINE_A_OFS);
    send(3'd4, LINE_A, 2'd2, 1'b0, 2'd0, "R7 matching invalidate");
    complete(3'd3, LINE_A, 2'd2);
    invalidate(LINE_B);
    send(3'd4, LINE_A, 2'd2, 1'b1, 2'd2, "R7 other-line invalidate");
    complete(3'd3, LINE_A, 2'd0);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_kind = 3'd3; cpl_addr = LINE_A; cpl_id = 2'd3;
    inv_valid = 1'b1; inv_addr = LINE_A;
    @(negedge clk);
    cpl_valid = 1'b0; inv_valid = 1'b0;
    send(3'd4, LINE_A, 2'd3, 1'b1, 2'd2, "R7 set wins over invalidate");

    // R8 back-pressure
    @(negedge clk);
    iss_ready = 1'b0;
    send(3'd0, 16'h0200, 2'd1, 1'b1, 2'd0, "R8 stalled load");
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h0300; req_id = 2'd2;
    for (int c = 0; c < 3; c++) begin
      check("R8 req_ready low", 32'(req_ready), 32'd0);
      check("R8 iss_addr held", 32'(iss_addr), 32'h0200);
      check("R8 iss_valid held", 32'(iss_valid), 32'd1);
      @(negedge clk);
      check("R9 no status while stalled", 32'(sts_valid), 32'd0);
    end
    iss_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 next payload", 32'(iss_addr), 32'h0300);
    check("R9 status after release", 32'(sts_valid), 32'd1);
    @(negedge clk);
    check("R9 single pulse", 32'(sts_valid), 32'd0);

    // R10 back-to-back store-conditionals
    complete(3'd3, LINE_B, 2'd1);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd4; req_addr = LINE_B; req_id = 2'd1;
    @(negedge clk);
    check("R10 first sc passes", 32'(sts_fail), 32'd0);
    check("R10 first sc issued", 32'(iss_valid), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second sc status", 32'(sts_valid), 32'd1);
    check("R10 second sc fails", 32'(sts_fail), 32'd1);
    check("R10 second sc not issued", 32'(iss_valid), 32'd0);

    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule